// File: doc/BRIEF.md
# Configurable Serial Shifter Port with Packed-Byte Transmit

This block is a per-processor serial transmitter and receiver. It sits behind a small request/acknowledge register interface. Software chooses a word length of 8, 16 or 32 bits. It also chooses whether each word is wrapped in a start bit and a stop bit. With framing on, the line behaves like an asynchronous serial link. With framing off, the block is a raw shift register, and a companion enable line marks the bits that carry data. In 8-bit mode an optional packed mode sends up to four bytes from one 32-bit write. The first byte always goes out; each later byte goes out only while it is non-zero.

Transmit writes and receive reads each come in two kinds. A blocking request is held until the block acknowledges it, so the requester stalls until the transmit holding register is free or a received word is present. A flag-returning request is acknowledged at once. It raises a busy or empty flag instead of waiting, and in that case nothing is stored or consumed.

The transmitter and the receiver each take their own baud tick from an external timing source. A bit lasts a fixed number of ticks. The receiver restarts its own sampling phase at every start event, so it does not need to share a phase with the transmitter. A status group reports transmit-busy, receive-data-available, overrun and framing error.

Top module: `serdes_port`

## Requirements
- R1: Data is shifted least significant bit first. `cfg_len` selects the word length: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. A received word is zero-extended into `rx_data`.
- R2: With `cfg_frame`=1 each word is sent as a low start bit, the data bits, then a high stop bit. With `cfg_frame`=0 only the data bits are sent, and `ser_oe` is high for exactly the data bits. `ser_out` is high whenever `ser_oe` is low.
- R3: With `cfg_len`=0 and `cfg_pack`=1, one write sends byte 0 (bits 7:0) and then bytes 1, 2 and 3 in that order. Sending stops before the first of these later bytes that is 0x00. With any other length, `cfg_pack` has no effect and one word is sent.
- R4: A blocking write (`tx_nb`=0) is not acknowledged while the transmit holding register is full. It is accepted in the first cycle in which the register is free.
- R5: A flag-returning write (`tx_nb`=1) is acknowledged in the cycle it is presented. It stores the data and shows `tx_busy_flag`=0 if the register is free. Otherwise it shows `tx_busy_flag`=1, leaves the register unchanged, and the rejected data is never sent.
- R6: A blocking read (`rx_nb`=0) is acknowledged only while a received word is available, and it consumes that word. A flag-returning read with nothing available is acknowledged with `rx_empty_flag`=1 and consumes nothing.
- R7: If a new word completes while the previous one is still unread, `st_overrun` is set and the newer word replaces the older one. An accepted read clears the flag.
- R8: A framed word whose stop bit samples low sets `st_frame_err`; the word is still delivered. An accepted read clears the flag.
- R9: Each bit lasts OVS ticks of its own direction's tick input. The receiver starts counting at a falling edge of `ser_in` (framed) or a rising edge of `ser_en_in` (unframed), and samples each bit at mid-bit.
- R10: `st_tx_busy` is high from an accepted write until the last bit of that write has left the line.
- R11: After reset, `ser_out`=1, `ser_oe`=0, all status outputs are 0 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_tick | input | 1 | Transmit baud tick, OVS ticks per bit |
| rx_tick | input | 1 | Receive baud tick, OVS ticks per bit |
| cfg_len | input | 2 | Word length select (0: 8, 1: 16, else 32) |
| cfg_frame | input | 1 | Add start and stop bits when 1 |
| cfg_pack | input | 1 | Packed-byte transmit in 8-bit mode |
| tx_req | input | 1 | Transmit write request |
| tx_nb | input | 1 | Flag-returning write when 1, blocking when 0 |
| tx_data | input | 32 | Transmit write data |
| tx_ack | output | 1 | Write request acknowledged this cycle |
| tx_busy_flag | output | 1 | Flag-returning write refused (register full) |
| rx_req | input | 1 | Receive read request |
| rx_nb | input | 1 | Flag-returning read when 1, blocking when 0 |
| rx_ack | output | 1 | Read request acknowledged this cycle |
| rx_empty_flag | output | 1 | Flag-returning read found no data |
| rx_data | output | 32 | Last received word, zero-extended |
| ser_out | output | 1 | Serial transmit line |
| ser_oe | output | 1 | High while the transmitter shifts bits |
| ser_in | input | 1 | Serial receive line |
| ser_en_in | input | 1 | Receive data enable for unframed mode |
| st_tx_busy | output | 1 | Transmitter holds or shifts data |
| st_rx_avail | output | 1 | Received word waiting to be read |
| st_overrun | output | 1 | Unread word was overwritten |
| st_frame_err | output | 1 | Stop bit sampled low |

## Verification
Most internal faults show up quickly at the ports. A wrong segment count or an error in the zero-byte test in packed mode shows as a missing or extra word at the receive side, within one frame time of the write. A holding-register flag that is stuck full or stuck empty shows on the first blocking or flag-returning write: a stall that never ends, or data that is lost or sent twice. A sampling phase that is off by half a bit, or a bit counter that is off by one, corrupts the very next looped-back word. The bench also decodes the line itself and times the bits, so a mirrored error in both directions is still caught.

// File: rtl/serdes_pkg.sv
package serdes_pkg;

  typedef enum logic [1:0] {
    LEN8  = 2'd0,
    LEN16 = 2'd1,
    LEN32 = 2'd2
  } wlen_e;

  // number of data bits for a length code
  function automatic logic [5:0] word_bits(input logic [1:0] len);
    case (len)
      LEN8:    return 6'd8;
      LEN16:   return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  // data bits plus optional start and stop
  function automatic logic [5:0] frame_bits(input logic [1:0] len, input logic framed);
    return word_bits(len) + (framed ? 6'd2 : 6'd0);
  endfunction

  // line vector, bit 0 leaves first
  function automatic logic [33:0] frame_vec(input logic [31:0] d, input logic [5:0] n,
                                            input logic framed);
    logic [33:0] m;
    logic [33:0] v;
    m = (34'd1 << n) - 34'd1;
    v = {2'b00, d} & m;
    if (framed) v = (v << 1) | (34'd1 << (n + 6'd1));
    return v;
  endfunction

  // right-aligned shift register holds newest bit at the top
  function automatic logic [31:0] align_rx(input logic [31:0] sh, input logic [5:0] n);
    return sh >> (6'd32 - n);
  endfunction

endpackage

// File: rtl/serdes_tx.sv
module serdes_tx
  import serdes_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [1:0]  len,
  input  logic        framed,
  input  logic        pack_en,
  input  logic        wr_req,
  input  logic [31:0] wr_data,
  output logic        wr_take,
  output logic        hold_full_o,
  output logic [31:0] hold_q_o,
  output logic        line,
  output logic        line_en,
  output logic        busy
);
  localparam int SUBW = $clog2(OVS);

  logic [31:0]     hold_q;
  logic            hold_full;
  logic            shifting;
  logic [33:0]     sh;
  logic [5:0]      left;
  logic [SUBW-1:0] sub;
  logic [23:0]     rem_q;
  logic [1:0]      rem_n;

  logic bit_end, seg_done, more, start_word, pack_on;

  assign wr_take    = wr_req & ~hold_full;
  assign bit_end    = shifting & tick & (sub == SUBW'(OVS - 1));
  assign seg_done   = bit_end & (left == 6'd1);
  assign more       = (rem_n != 2'd0) & (rem_q[7:0] != 8'h00);
  assign start_word = ~shifting & hold_full;
  assign pack_on    = pack_en & (len == LEN8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      shifting  <= 1'b0;
      sh        <= '0;
      left      <= '0;
      sub       <= '0;
      rem_q     <= '0;
      rem_n     <= '0;
    end else begin
      if (wr_take) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end else if (start_word) begin
        hold_full <= 1'b0;
      end

      if (start_word) begin
        shifting <= 1'b1;
        sh       <= frame_vec(hold_q, word_bits(len), framed);
        left     <= frame_bits(len, framed);
        sub      <= '0;
        rem_q    <= hold_q[31:8];
        rem_n    <= pack_on ? 2'd3 : 2'd0;
      end else if (seg_done) begin
        if (more) begin
          sh    <= frame_vec({24'd0, rem_q[7:0]}, 6'd8, framed);
          left  <= frame_bits(LEN8, framed);
          rem_q <= rem_q >> 8;
          rem_n <= rem_n - 2'd1;
          sub   <= '0;
        end else begin
          shifting <= 1'b0;
        end
      end else if (bit_end) begin
        sh   <= sh >> 1;
        left <= left - 6'd1;
        sub  <= '0;
      end else if (shifting & tick) begin
        sub <= sub + SUBW'(1);
      end
    end
  end

  assign line        = shifting ? sh[0] : 1'b1;
  assign line_en     = shifting;
  assign busy        = hold_full | shifting;
  assign hold_full_o = hold_full;
  assign hold_q_o    = hold_q;
endmodule

// File: rtl/serdes_rx.sv
module serdes_rx
  import serdes_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [1:0]  len,
  input  logic        framed,
  input  logic        line_in,
  input  logic        en_in,
  output logic        done,
  output logic [31:0] word,
  output logic        stop_bad
);
  localparam int SUBW = $clog2(OVS);

  logic            active;
  logic [5:0]      idx;
  logic [SUBW-1:0] sub;
  logic [31:0]     sh;
  logic            line_q, en_q;

  logic [5:0] nbits, last_idx;
  logic       start_ev, samp, abort;

  assign nbits    = word_bits(len);
  assign last_idx = framed ? nbits + 6'd1 : nbits - 6'd1;
  assign start_ev = ~active & (framed ? (line_q & ~line_in) : (~en_q & en_in));
  assign samp     = active & tick & (sub == SUBW'(OVS - 1));
  assign abort    = active & ~framed & ~en_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      sub    <= '0;
      sh     <= '0;
      line_q <= 1'b1;
      en_q   <= 1'b0;
    end else begin
      line_q <= line_in;
      en_q   <= en_in;
      if (start_ev) begin
        active <= 1'b1;
        idx    <= '0;
        sub    <= SUBW'(OVS / 2);
      end else if (abort) begin
        active <= 1'b0;
      end else if (samp) begin
        sub <= '0;
        if (framed && idx == 6'd0) begin
          if (line_in) active <= 1'b0;
          else         idx    <= 6'd1;
        end else if (framed && idx == last_idx) begin
          active <= 1'b0;
        end else begin
          sh  <= {line_in, sh[31:1]};
          idx <= (!framed && idx == last_idx) ? 6'd0 : idx + 6'd1;
        end
      end else if (active & tick) begin
        sub <= sub + SUBW'(1);
      end
    end
  end

  assign done     = samp & ~abort & (idx == last_idx);
  assign word     = framed ? align_rx(sh, nbits) : align_rx({line_in, sh[31:1]}, nbits);
  assign stop_bad = framed & ~line_in;
endmodule

// File: rtl/serdes_port.sv
module serdes_port
  import serdes_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_tick,
  input  logic        rx_tick,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_frame,
  input  logic        cfg_pack,
  input  logic        tx_req,
  input  logic        tx_nb,
  input  logic [31:0] tx_data,
  output logic        tx_ack,
  output logic        tx_busy_flag,
  input  logic        rx_req,
  input  logic        rx_nb,
  output logic        rx_ack,
  output logic        rx_empty_flag,
  output logic [31:0] rx_data,
  output logic        ser_out,
  output logic        ser_oe,
  input  logic        ser_in,
  input  logic        ser_en_in,
  output logic        st_tx_busy,
  output logic        st_rx_avail,
  output logic        st_overrun,
  output logic        st_frame_err
);
  // internal events brought out for the checker
  logic        tx_take;
  logic        tx_hold_full;
  logic [31:0] tx_hold_q;
  logic        rx_word_done;
  logic [31:0] rx_word;
  logic        rx_stop_bad;
  logic        rd_take;

  logic [31:0] rxd_q;
  logic        avail_q, ovr_q, ferr_q;

  serdes_tx #(.OVS(OVS)) i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .len(cfg_len), .framed(cfg_frame),
    .pack_en(cfg_pack), .wr_req(tx_req), .wr_data(tx_data), .wr_take(tx_take),
    .hold_full_o(tx_hold_full), .hold_q_o(tx_hold_q), .line(ser_out),
    .line_en(ser_oe), .busy(st_tx_busy)
  );

  serdes_rx #(.OVS(OVS)) i_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .len(cfg_len), .framed(cfg_frame),
    .line_in(ser_in), .en_in(ser_en_in), .done(rx_word_done), .word(rx_word),
    .stop_bad(rx_stop_bad)
  );

  assign rd_take = rx_req & avail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_q   <= '0;
      avail_q <= 1'b0;
      ovr_q   <= 1'b0;
      ferr_q  <= 1'b0;
    end else if (rx_word_done) begin
      rxd_q   <= rx_word;
      avail_q <= 1'b1;
      ovr_q   <= avail_q & ~rd_take;
      ferr_q  <= rx_stop_bad | (ferr_q & ~rd_take);
    end else if (rd_take) begin
      avail_q <= 1'b0;
      ovr_q   <= 1'b0;
      ferr_q  <= 1'b0;
    end
  end

  assign tx_ack        = tx_take | (tx_req & tx_nb);
  assign tx_busy_flag  = tx_req & tx_nb & tx_hold_full;
  assign rx_ack        = rd_take | (rx_req & rx_nb);
  assign rx_empty_flag = rx_req & rx_nb & ~avail_q;
  assign rx_data       = rxd_q;
  assign st_rx_avail   = avail_q;
  assign st_overrun    = ovr_q;
  assign st_frame_err  = ferr_q;
endmodule

// File: rtl/serdes_port_chk.sv
module serdes_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_nb,
  input logic        tx_ack,
  input logic        tx_busy_flag,
  input logic        rx_nb,
  input logic        rx_ack,
  input logic        ser_out,
  input logic        ser_oe,
  input logic        st_tx_busy,
  input logic        st_rx_avail,
  input logic        st_overrun,
  input logic [31:0] tx_hold_q,
  input logic        rx_word_done
);
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> ser_out);

  // R4
  blk_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && !tx_nb) |=> st_tx_busy);

  // R5
  nb_reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy_flag |=> $stable(tx_hold_q));

  // R6
  blk_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !rx_nb) |-> st_rx_avail);

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && st_rx_avail && !rx_word_done) |=> !st_rx_avail);

  // R7
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_overrun) |-> $past(st_rx_avail));

  // R10
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy_flag |-> st_tx_busy);
endmodule

bind serdes_port serdes_port_chk i_serdes_port_chk (
  .clk(clk), .rst_n(rst_n), .tx_nb(tx_nb), .tx_ack(tx_ack),
  .tx_busy_flag(tx_busy_flag), .rx_nb(rx_nb), .rx_ack(rx_ack),
  .ser_out(ser_out), .ser_oe(ser_oe), .st_tx_busy(st_tx_busy),
  .st_rx_avail(st_rx_avail), .st_overrun(st_overrun),
  .tx_hold_q(tx_hold_q), .rx_word_done(rx_word_done)
);

// File: tb/test_serdes_port.sv
`timescale 1ns/1ps
module test_serdes_port;
  localparam int OVS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_tick = 1'b1, rx_tick = 1'b1;
  logic [1:0]  cfg_len = 2'd0;
  logic        cfg_frame = 1'b1, cfg_pack = 1'b0;
  logic        tx_req = 1'b0, tx_nb = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_ack, tx_busy_flag;
  logic        rx_req = 1'b0, rx_nb = 1'b0;
  logic        rx_ack, rx_empty_flag;
  logic [31:0] rx_data;
  logic        ser_out, ser_oe, ser_in, ser_en_in;
  logic        st_tx_busy, st_rx_avail, st_overrun, st_frame_err;
  logic        loop = 1'b1, drv_in = 1'b1, drv_en = 1'b0;

  int nchk = 0, nfail = 0;
  int div = 1, rx_phase = 0, txc = 0, rxc = 0;

  always #2.5 clk = ~clk;

  assign ser_in    = loop ? ser_out : drv_in;
  assign ser_en_in = loop ? ser_oe  : drv_en;

  always @(negedge clk) begin
    txc = (txc + 1) % div;
    rxc = (rxc + 1) % div;
    tx_tick = (txc == 0);
    rx_tick = (((rxc + rx_phase) % div) == 0);
  end

  serdes_port #(.OVS(OVS)) i_serdes_port (
    .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .rx_tick(rx_tick),
    .cfg_len(cfg_len), .cfg_frame(cfg_frame), .cfg_pack(cfg_pack),
    .tx_req(tx_req), .tx_nb(tx_nb), .tx_data(tx_data), .tx_ack(tx_ack),
    .tx_busy_flag(tx_busy_flag), .rx_req(rx_req), .rx_nb(rx_nb), .rx_ack(rx_ack),
    .rx_empty_flag(rx_empty_flag), .rx_data(rx_data), .ser_out(ser_out),
    .ser_oe(ser_oe), .ser_in(ser_in), .ser_en_in(ser_en_in),
    .st_tx_busy(st_tx_busy), .st_rx_avail(st_rx_avail),
    .st_overrun(st_overrun), .st_frame_err(st_frame_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  task automatic tx_write(input logic [31:0] d, input bit nb, output bit flag);
    @(negedge clk);
    tx_req = 1'b1; tx_nb = nb; tx_data = d;
    #1;
    while (!tx_ack) begin @(negedge clk); #1; end
    flag = tx_busy_flag;
    @(posedge clk); #1;
    tx_req = 1'b0; tx_nb = 1'b0;
  endtask

  task automatic rx_read(input bit nb, output logic [31:0] d, output bit flag,
                         output int waited);
    waited = 0;
    @(negedge clk);
    rx_req = 1'b1; rx_nb = nb;
    #1;
    while (!rx_ack) begin waited++; @(negedge clk); #1; end
    flag = rx_empty_flag;
    d = rx_data;
    @(posedge clk); #1;
    rx_req = 1'b0; rx_nb = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (st_tx_busy) @(negedge clk);
    repeat (3 * OVS * div) @(negedge clk);
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0403_0201;
      3: return 32'h0033_0011;
      4: return 32'h1200_3401;
      default: return 32'hA5C3_0F80;
    endcase
  endfunction

  function automatic int n_words(input logic [31:0] d, input int l, input bit p);
    int n = 1;
    bit go = 1'b1;
    if (l == 0 && p)
      for (int k = 1; k < 4; k++) begin
        if (go && d[8*k +: 8] != 8'h00) n++;
        else go = 1'b0;
      end
    return n;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] d, input int l, input int k);
    if (l == 0) return (d >> (8 * k)) & 32'h0000_00FF;
    if (l == 1) return d & 32'h0000_FFFF;
    return d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit fl;
    int w, cnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R11 reset state
    chk(ser_out === 1'b1, "R11 ser_out idle", {31'd0, ser_out}, 32'd1);
    chk(ser_oe === 1'b0, "R11 ser_oe", {31'd0, ser_oe}, 32'd0);
    chk({st_tx_busy, st_rx_avail, st_overrun, st_frame_err} === 4'b0, "R11 status",
        {28'd0, st_tx_busy, st_rx_avail, st_overrun, st_frame_err}, 32'd0);
    chk(rx_data === 32'd0, "R11 rx_data", rx_data, 32'd0);

    // R6 flag-returning read when empty
    rx_read(1'b1, d, fl, w);
    chk(fl == 1'b1 && w == 0, "R6 nb read empty flag", {31'd0, fl}, 32'd1);
    chk(st_rx_avail == 1'b0, "R6 nb empty read consumed nothing", {31'd0, st_rx_avail}, 32'd0);

    // R2 framed line decode, R10 busy
    cfg_len = 2'd0; cfg_frame = 1'b1; cfg_pack = 1'b0;
    tx_write(32'h0000_00C5, 1'b0, fl);
    #1;
    chk(st_tx_busy == 1'b1, "R10 busy after write", {31'd0, st_tx_busy}, 32'd1);
    begin
      logic [9:0] seen;
      @(negedge clk);
      while (ser_out) @(negedge clk);
      repeat (OVS / 2) @(negedge clk);
      for (int b = 0; b < 10; b++) begin
        seen[b] = ser_out;
        repeat (OVS) @(negedge clk);
      end
      chk(seen == {1'b1, 8'hC5, 1'b0}, "R2 R1 framed line LSB first",
          {22'd0, seen}, {22'd0, 1'b1, 8'hC5, 1'b0});
    end
    rx_read(1'b0, d, fl, w);
    chk(d == 32'h0000_00C5, "R1 loopback 8b", d, 32'h0000_00C5);
    wait_idle();
    chk(st_tx_busy == 1'b0, "R10 idle after frame", {31'd0, st_tx_busy}, 32'd0);

    // R2 unframed: enable high exactly for data bits
    cfg_len = 2'd1; cfg_frame = 1'b0;
    tx_write(32'hDEAD_9A3C, 1'b0, fl);
    begin
      int hi = 0;
      logic [15:0] seen;
      @(negedge clk);
      while (!ser_oe) @(negedge clk);
      for (int b = 0; b < 16 * OVS; b++) begin
        if (b % OVS == OVS / 2) seen[b / OVS] = ser_out;
        if (ser_oe) hi++;
        @(negedge clk);
      end
      chk(ser_oe == 1'b0 && hi == 16 * OVS, "R2 unframed enable length", hi, 16 * OVS);
      chk(seen == 16'h9A3C, "R2 R1 unframed bits", {16'd0, seen}, 32'h9A3C);
    end
    rx_read(1'b0, d, fl, w);
    chk(d == 32'h0000_9A3C, "R1 unframed 16b zero extend", d, 32'h9A3C);
    wait_idle();

    // R1 R3 sweep over length, framing, packing and data patterns
    for (int l = 0; l < 3; l++)
      for (int f = 0; f < 2; f++)
        for (int p = 0; p < 2; p++)
          for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cfg_len = l[1:0]; cfg_frame = f[0]; cfg_pack = p[0];
            tx_write(pat(i), 1'b0, fl);
            cnt = n_words(pat(i), l, p[0]);
            for (int k = 0; k < cnt; k++) begin
              rx_read(1'b0, d, fl, w);
              chk(d == exp_word(pat(i), l, k), "R1 R3 sweep word", d, exp_word(pat(i), l, k));
            end
            wait_idle();
            chk(st_rx_avail == 1'b0 && st_overrun == 1'b0, "R3 no extra word",
                {30'd0, st_rx_avail, st_overrun}, 32'd0);
          end

    // R4 blocking write stalls while holding register full
    cfg_len = 2'd0; cfg_frame = 1'b1; cfg_pack = 1'b0;
    tx_write(32'h11, 1'b0, fl);
    tx_write(32'h22, 1'b0, fl);
    begin
      int stall = 0;
      @(negedge clk);
      tx_req = 1'b1; tx_nb = 1'b0; tx_data = 32'h33;
      #1;
      while (!tx_ack) begin stall++; @(negedge clk); #1; end
      @(posedge clk); #1;
      tx_req = 1'b0;
      chk(stall > OVS, "R4 blocking write stalled", stall, OVS);
    end
    for (int k = 0; k < 3; k++) begin
      rx_read(1'b0, d, fl, w);
      chk(d == 32'h11 * (k + 1), "R4 stalled write order", d, 32'h11 * (k + 1));
    end
    wait_idle();

    // R5 flag-returning write
    tx_write(32'h44, 1'b0, fl);
    tx_write(32'h55, 1'b0, fl);
    tx_write(32'h66, 1'b1, fl);
    chk(fl == 1'b1, "R5 nb write busy flag", {31'd0, fl}, 32'd1);
    rx_read(1'b0, d, fl, w);
    chk(d == 32'h44, "R5 first word", d, 32'h44);
    rx_read(1'b0, d, fl, w);
    chk(d == 32'h55, "R5 held word unchanged", d, 32'h55);
    wait_idle();
    chk(st_rx_avail == 1'b0, "R5 rejected data never sent", {31'd0, st_rx_avail}, 32'd0);
    tx_write(32'h77, 1'b1, fl);
    chk(fl == 1'b0, "R5 nb write accepted flag", {31'd0, fl}, 32'd0);
    rx_read(1'b0, d, fl, w);
    chk(d == 32'h77, "R5 nb accepted word", d, 32'h77);
    wait_idle();

    // R6 blocking read stalls until data arrives
    fork
      begin
        rx_read(1'b0, d, fl, w);
      end
      begin
        repeat (20) @(negedge clk);
        tx_write(32'h3C, 1'b0, fl);
      end
    join
    chk(d == 32'h3C && w > 20, "R6 blocking read waited", w, 21);
    wait_idle();

    // R7 overrun
    tx_write(32'h81, 1'b0, fl);
    tx_write(32'h82, 1'b0, fl);
    wait_idle();
    chk(st_overrun == 1'b1, "R7 overrun set", {31'd0, st_overrun}, 32'd1);
    rx_read(1'b0, d, fl, w);
    chk(d == 32'h82, "R7 newer word kept", d, 32'h82);
    @(negedge clk);
    chk(st_overrun == 1'b0 && st_rx_avail == 1'b0, "R7 read clears overrun",
        {30'd0, st_overrun, st_rx_avail}, 32'd0);

    // R8 framing error from a driven line
    loop = 1'b0; drv_in = 1'b1;
    repeat (4) @(negedge clk);
    begin
      logic [9:0] bits;
      bits = {1'b0, 8'hA5, 1'b0};
      for (int b = 0; b < 10; b++) begin
        drv_in = bits[b];
        repeat (OVS) @(negedge clk);
      end
      drv_in = 1'b1;
      repeat (OVS) @(negedge clk);
    end
    chk(st_frame_err == 1'b1, "R8 frame error set", {31'd0, st_frame_err}, 32'd1);
    rx_read(1'b0, d, fl, w);
    chk(d == 32'hA5, "R8 word still delivered", d, 32'hA5);
    @(negedge clk);
    chk(st_frame_err == 1'b0, "R8 read clears frame error", {31'd0, st_frame_err}, 32'd0);
    loop = 1'b1;
    repeat (4) @(negedge clk);

    // R9 slower ticks, receiver on a different tick phase
    div = 3; rx_phase = 1;
    repeat (6) @(negedge clk);
    tx_write(32'h55, 1'b0, fl);
    begin
      int hi = 0;
      @(negedge clk);
      while (ser_out) @(negedge clk);
      while (!ser_out) @(negedge clk);
      while (ser_out) begin hi++; @(negedge clk); end
      chk(hi == OVS * 3, "R9 bit length in ticks", hi, OVS * 3);
    end
    rx_read(1'b0, d, fl, w);
    chk(d == 32'h55, "R9 loopback with slow ticks", d, 32'h55);
    wait_idle();

    report();
    $finish;
  end
endmodule